// File: doc/BRIEF.md
# CAN Error Event Capture and Interrupt Summary

This block sits beside the protocol engine of a CAN controller and turns the engine's error reporting into state that a CPU can read. The engine delivers single-cycle pulses for eight error events and for seven individual protocol error types. Each event pulse sets a sticky flag. Each protocol error type sets a bit in an error code byte. A per-bit enable byte selects which flags contribute to a summary error status, and that status, gated by its own enable, drives the error interrupt line. The transmit and receive error counts that the engine keeps are registered here so that software can read them.

Software works through a byte-wide register port with a 3-bit address. It clears a sticky bit by writing 0 to it, and bits written as 1 keep their value, so a handler can acknowledge exactly the causes it has serviced. A mode bit in the code byte selects whether protocol error codes pile up across errors or show only the most recent error. A two-state machine holds the summary status. The state `SUM_QUIET` moves to `SUM_RAISED` on the transition *pending seen*, when any enabled flag is 1. The state `SUM_RAISED` returns to `SUM_QUIET` on the transition *all serviced*, when no enabled flag remains.

Top module: `can_err_capture`

## Requirements
- R1: After reset, every register address (0 to 7) reads 0 and `err_irq_o` is 0. Address 7 always reads 0.
- R2: The event flag byte (address 0) latches a pulse on `evt_i[i]` into bit i at the next clock edge. From bit 7 down to bit 0 the bits are: bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error. A flag latches whatever the state of its enable bit.
- R3: A write to address 0 clears each flag bit written as 0. Each flag bit written as 1 keeps its value.
- R4: When an event pulse and a clearing write reach the same bit in the same cycle, the bit is 1 afterwards. This also holds for the code bits at address 2.
- R5: The flag enable byte (address 1) is a plain read/write byte that uses the same bit positions as the flag byte. The summary status reads as bit 5 of address 5. It becomes 1 one cycle after any flag AND its enable is 1, and it becomes 0 one cycle after none is.
- R6: The interrupt enable byte (address 6) stores only bit 5, and its other bits read 0. `err_irq_o` equals the summary status AND that bit. Writes to address 5 have no effect.
- R7: In the error code byte (address 2), bit 6 is ACK delimiter, bit 5 is bit error dominant, bit 4 is bit error recessive, bit 3 is CRC, bit 2 is ACK, bit 1 is form and bit 0 is stuff. These bits follow `perr_i[6:0]`. Bit 7 is the display mode. When bit 7 is 1, new errors OR into the code bits that are already set.
- R8: When bit 7 is 0 and any `perr_i` bit pulses, code bits 6:0 become exactly the pulsed bits, and the bits set earlier are dropped.
- R9: A write to address 2 loads bit 7 from the written data. It clears each code bit written as 0 and keeps each code bit written as 1. An error pulsed in the same cycle still lands as R7 and R8 state.
- R10: Address 3 reads the transmit error count and address 4 reads the receive error count. Each shows the value that `tx_cnt_i` or `rx_cnt_i` had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Error event pulses, in the bit order of the flag byte |
| perr_i | input | 7 | Protocol error type pulses, in the bit order of the code byte |
| tx_cnt_i | input | 8 | Transmit error count from the engine |
| rx_cnt_i | input | 8 | Receive error count from the engine |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_addr_i | input | 3 | Register address |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data for `cpu_addr_i`, same cycle |
| err_irq_o | output | 1 | Summary error interrupt |

## Verification
The assertions assume that the engine's pulse inputs, the counts and the CPU strobe carry known values at every clock edge after reset. They also assume that an event can arrive in any cycle, including a cycle in which the CPU writes to the same register. The stimulus keeps to this. It drives only defined values, a sparse random mix of single and multi-bit pulses, random writes to all eight addresses, and directed cases in which a pulse and a clearing write meet. The flag checks also rely on each pulse input meaning one event per high cycle, so the stimulus never holds a pulse for more than one cycle on purpose.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int N_EVT    = 8;
    localparam int N_CODE   = 7;
    localparam int SUM_BIT  = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG   = 3'd0,
        REG_FLAGEN = 3'd1,
        REG_CODE   = 3'd2,
        REG_TXCNT  = 3'd3,
        REG_RXCNT  = 3'd4,
        REG_STAT   = 3'd5,
        REG_IRQEN  = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic {
        SUM_QUIET  = 1'b0,
        SUM_RAISED = 1'b1
    } sum_state_e;
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_flag_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] en_o
);
    logic [N-1:0] flag_q;
    logic [N-1:0] en_q;

    // one sticky cell per event; the set input dominates the clearing write
    for (genvar g = 0; g < N; g++) begin : g_cell
        logic clr;
        assign clr = wr_flag_i && !wdata_i[g];
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[g] <= 1'b0;
            else if (evt_i[g])   flag_q[g] <= 1'b1;
            else if (clr)        flag_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_en_i) en_q <= wdata_i;
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R4
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag_i && evt_i == '0) |=> (flag_q == ($past(flag_q) & $past(wdata_i)))); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag_i && evt_i == '0) |=> $stable(flag_q)); // R2
endmodule

// File: rtl/err_code_store.sv
module err_code_store #(
    parameter int NC = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [NC-1:0] perr_i,
    input  logic        wr_i,
    input  logic [NC:0] wdata_i,
    output logic [NC:0] code_o
);
    logic          accum_q;
    logic [NC-1:0] bits_q;
    logic [NC-1:0] kept;
    logic [NC-1:0] bits_d;

    always_comb begin
        kept = wr_i ? (bits_q & wdata_i[NC-1:0]) : bits_q;
        if (accum_q)
            bits_d = kept | perr_i;
        else if (perr_i != '0)
            bits_d = perr_i;
        else
            bits_d = kept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accum_q <= 1'b0;
            bits_q  <= '0;
        end else begin
            bits_q <= bits_d;
            if (wr_i) accum_q <= wdata_i[NC];
        end
    end

    assign code_o = {accum_q, bits_q};

    AST_LATEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!accum_q && perr_i != '0) |=> (bits_q == $past(perr_i))); // R8
    AST_ACCUM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accum_q && perr_i != '0 && !wr_i) |=> (bits_q == ($past(bits_q) | $past(perr_i)))); // R7
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (accum_q == $past(wdata_i[NC]))); // R9
endmodule

// File: rtl/err_summary_fsm.sv
module err_summary_fsm
    import can_err_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         raised_o
);
    sum_state_e state_q, state_d;
    logic       pending;

    assign pending = |(flag_i & en_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_QUIET:  if (pending)  state_d = SUM_RAISED; // pending seen
            SUM_RAISED: if (!pending) state_d = SUM_QUIET;  // all serviced
            default:                  state_d = SUM_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SUM_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        raised_o = (state_q == SUM_RAISED);
    end

    AST_RAISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> raised_o); // R5
    AST_DROP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !raised_o); // R5
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
    import can_err_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_EVT-1:0]    evt_i,
    input  logic [N_CODE-1:0]   perr_i,
    input  logic [BYTE_W-1:0]   tx_cnt_i,
    input  logic [BYTE_W-1:0]   rx_cnt_i,
    input  logic                cpu_wr_i,
    input  logic [ADDR_W-1:0]   cpu_addr_i,
    input  logic [BYTE_W-1:0]   cpu_wdata_i,
    output logic [BYTE_W-1:0]   cpu_rdata_o,
    output logic                err_irq_o
);
    logic [N_EVT-1:0]  flags;
    logic [N_EVT-1:0]  flag_en;
    logic [N_CODE:0]   code;
    logic              raised;
    logic              irq_en_q;
    logic [BYTE_W-1:0] tx_cnt_q;
    logic [BYTE_W-1:0] rx_cnt_q;
    logic              wr_flag, wr_flagen, wr_code, wr_irqen;

    assign wr_flag   = cpu_wr_i && (cpu_addr_i == REG_FLAG);
    assign wr_flagen = cpu_wr_i && (cpu_addr_i == REG_FLAGEN);
    assign wr_code   = cpu_wr_i && (cpu_addr_i == REG_CODE);
    assign wr_irqen  = cpu_wr_i && (cpu_addr_i == REG_IRQEN);

    err_flag_bank #(.N(N_EVT)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_flag_i (wr_flag),
        .wr_en_i   (wr_flagen),
        .wdata_i   (cpu_wdata_i),
        .flag_o    (flags),
        .en_o      (flag_en)
    );

    err_code_store #(.NC(N_CODE)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .perr_i  (perr_i),
        .wr_i    (wr_code),
        .wdata_i (cpu_wdata_i[N_CODE:0]),
        .code_o  (code)
    );

    err_summary_fsm #(.N(N_EVT)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   (flags),
        .en_i     (flag_en),
        .raised_o (raised)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            tx_cnt_q <= '0;
            rx_cnt_q <= '0;
        end else begin
            tx_cnt_q <= tx_cnt_i;
            rx_cnt_q <= rx_cnt_i;
            if (wr_irqen) irq_en_q <= cpu_wdata_i[SUM_BIT];
        end
    end

    always_comb begin
        cpu_rdata_o = '0;
        unique case (cpu_addr_i)
            REG_FLAG:   cpu_rdata_o = flags;
            REG_FLAGEN: cpu_rdata_o = flag_en;
            REG_CODE:   cpu_rdata_o = code;
            REG_TXCNT:  cpu_rdata_o = tx_cnt_q;
            REG_RXCNT:  cpu_rdata_o = rx_cnt_q;
            REG_STAT:   cpu_rdata_o[SUM_BIT] = raised;
            REG_IRQEN:  cpu_rdata_o[SUM_BIT] = irq_en_q;
            default:    cpu_rdata_o = '0;
        endcase
    end

    assign err_irq_o = raised && irq_en_q;

    AST_TX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tx_cnt_q == $past(tx_cnt_i))); // R10
    AST_RX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rx_cnt_q == $past(rx_cnt_i))); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq_o && !$past(wr_flag) && !$past(wr_flagen)) |-> ($past(flags & flag_en) != '0)); // R6
endmodule

// File: tb/test_can_err_capture.sv
module test_can_err_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic [6:0] perr_i = '0;
    logic [7:0] tx_cnt_i = '0, rx_cnt_i = '0;
    logic       cpu_wr_i = 1'b0;
    logic [2:0] cpu_addr_i = '0;
    logic [7:0] cpu_wdata_i = '0;
    logic [7:0] cpu_rdata_o;
    logic       err_irq_o;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // reference state, derived from the requirements
    logic [7:0] m_flag = '0, m_en = '0, m_code = '0, m_tx = '0, m_rx = '0;
    logic       m_sum = 1'b0, m_ier = 1'b0;

    always #4 clk = ~clk;

    can_err_capture i_can_err_capture (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .perr_i(perr_i),
        .tx_cnt_i(tx_cnt_i), .rx_cnt_i(rx_cnt_i), .cpu_wr_i(cpu_wr_i),
        .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_rdata_o(cpu_rdata_o), .err_irq_o(err_irq_o)
    );

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_flag;
            3'd1: return m_en;
            3'd2: return m_code;
            3'd3: return m_tx;
            3'd4: return m_rx;
            3'd5: return {2'b00, m_sum, 5'b0};
            3'd6: return {2'b00, m_ier, 5'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R5";
            3'd2: return "R7";
            3'd3, 3'd4: return "R10";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, check before the edge, then advance the reference
    task automatic step(input logic [7:0] ev, input logic [6:0] pe, input logic wr,
                        input logic [2:0] a, input logic [7:0] wd, input string tag);
        logic [6:0] kept;
        @(negedge clk);
        evt_i = ev; perr_i = pe; cpu_wr_i = wr; cpu_addr_i = a; cpu_wdata_i = wd;
        tx_cnt_i = 8'($urandom); rx_cnt_i = 8'($urandom);
        #1;
        if (!wr) check8(tag, cpu_rdata_o, exp_read(a));
        check8("R6 irq", {7'b0, err_irq_o}, {7'b0, m_sum & m_ier});
        @(posedge clk);
        m_sum = |(m_flag & m_en);
        m_flag = ev | ((wr && a == 3'd0) ? (m_flag & wd) : m_flag);
        if (wr && a == 3'd1) m_en = wd;
        kept = (wr && a == 3'd2) ? (m_code[6:0] & wd[6:0]) : m_code[6:0];
        if (m_code[7])       m_code[6:0] = kept | pe;
        else if (pe != '0)   m_code[6:0] = pe;
        else                 m_code[6:0] = kept;
        if (wr && a == 3'd2) m_code[7] = wd[7];
        if (wr && a == 3'd6) m_ier = wd[5];
        m_tx = tx_cnt_i; m_rx = rx_cnt_i;
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset values at every address
        for (int a = 0; a < 8; a++) step(8'h00, 7'h00, 1'b0, 3'(a), 8'h00, "R1 reset");
        // R2: bus-off entry pulse lands in bit 3
        step(8'h08, 7'h00, 1'b0, 3'd0, 8'h00, "R2");
        step(8'h00, 7'h00, 1'b0, 3'd0, 8'h00, "R2 bus-off entry flag");
        // R3: write 0 to bit 3 only
        step(8'h00, 7'h00, 1'b1, 3'd0, 8'hF7, "R3");
        step(8'h00, 7'h00, 1'b0, 3'd0, 8'h00, "R3 cleared by zero");
        // R4: set and clear meet on bit 0
        step(8'h01, 7'h00, 1'b1, 3'd0, 8'h00, "R4");
        step(8'h00, 7'h00, 1'b0, 3'd0, 8'h00, "R4 set wins");
        // R5 / R6: enable bus error and the summary interrupt
        step(8'h00, 7'h00, 1'b1, 3'd1, 8'h01, "R5");
        step(8'h00, 7'h00, 1'b1, 3'd6, 8'hFF, "R6");
        step(8'h00, 7'h00, 1'b0, 3'd5, 8'h00, "R5 status raised");
        step(8'h00, 7'h00, 1'b1, 3'd5, 8'h00, "R6");
        step(8'h00, 7'h00, 1'b0, 3'd6, 8'h00, "R6 enable only bit 5");
        step(8'h00, 7'h00, 1'b1, 3'd0, 8'h00, "R3");
        step(8'h00, 7'h00, 1'b0, 3'd5, 8'h00, "R5 status still set one cycle");
        step(8'h00, 7'h00, 1'b0, 3'd5, 8'h00, "R5 status dropped");
        // R7: accumulate mode
        step(8'h00, 7'h00, 1'b1, 3'd2, 8'h80, "R7");
        step(8'h00, 7'h01, 1'b0, 3'd2, 8'h00, "R7");
        step(8'h00, 7'h08, 1'b0, 3'd2, 8'h00, "R7");
        step(8'h00, 7'h00, 1'b0, 3'd2, 8'h00, "R7 accumulated stuff and CRC");
        // R8: latest mode replaces
        step(8'h00, 7'h00, 1'b1, 3'd2, 8'h7F, "R9");
        step(8'h00, 7'h00, 1'b0, 3'd2, 8'h00, "R9 mode cleared, bits kept");
        step(8'h00, 7'h40, 1'b0, 3'd2, 8'h00, "R8");
        step(8'h00, 7'h00, 1'b0, 3'd2, 8'h00, "R8 ACK delimiter alone");
        // R9: clearing write and new error in the same cycle
        step(8'h00, 7'h02, 1'b1, 3'd2, 8'h00, "R9");
        step(8'h00, 7'h00, 1'b0, 3'd2, 8'h00, "R9 new error survives clear");
        // R10: counts
        step(8'h00, 7'h00, 1'b0, 3'd3, 8'h00, "R10 tx count");
        step(8'h00, 7'h00, 1'b0, 3'd4, 8'h00, "R10 rx count");
        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] ev;
            logic [6:0] pe;
            logic       wr;
            logic [2:0] a;
            ev = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            pe = ($urandom % 5 == 0) ? 7'($urandom) & 7'($urandom) : 7'h00;
            wr = ($urandom % 4 == 0);
            a  = 3'($urandom);
            step(ev, pe, wr, a, 8'($urandom), tag_of(a));
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule